// File: doc/BRIEF.md
# Video Controller CPU Register Interface

This block is the processor-facing register file of a tile-based video controller. The processor sees eight byte-wide registers, picked by the three low address bits. The decode that places this window at its mirrored system addresses lives outside the block. Through these registers software sets the control and mask bytes, polls and acknowledges the vertical-blank flag, and fills sprite-attribute memory. It also loads the scroll position and the video memory address, and streams bytes into and out of video memory.

Scroll and address setup each take two byte writes. One write-order toggle is shared by both registers. The writes are packed into a 15-bit temporary address and a 3-bit fine horizontal scroll. The second address write copies the temporary address into the current video address. Reads of the video data register come through a one-byte buffer, so each read returns the byte fetched by the read before it. Addresses from 0x3F00 upward select a 32-entry palette held inside the block. All other addresses go out on a combinational video-memory port.

Top module: `vid_regif`

## Requirements
- R1: After reset the temporary address, current video address, fine X, write toggle, vblank flag, control byte, mask byte and read data are all zero.
- R2: A read of register 2 returns {vblank, 7'b0}, then clears the vblank flag and the write toggle. A vblank_set pulse in the same cycle as that read is lost. A vblank_set pulse in any other cycle sets the flag.
- R3: A write to register 0 stores the control byte and copies data[1:0] into temporary address bits [11:10]. Control bit 2 set makes every video data access step the current address by 32; clear makes it step by 1.
- R4: Register 5 is the scroll register. A write with the toggle at 0 puts data[7:3] in t[4:0] and data[2:0] in fine X. A write with the toggle at 1 puts data[7:3] in t[9:5] and data[2:0] in t[14:12].
- R5: Register 6 is the address register. A write with the toggle at 0 puts data[5:0] in t[13:8] and clears t[14]. A write with the toggle at 1 puts data in t[7:0] and then loads the current address with {0, t[13:0]}.
- R6: Every write to register 5 or register 6 inverts the single shared write toggle.
- R7: A read of register 7 returns the read buffer's old contents. The buffer then reloads from the current address taken to 14 bits, and the address steps.
- R8: A write to register 7 stores the byte at the current address and steps the address. Outside the palette range it drives vmem_we with vmem_addr = current address [13:0] in that cycle.
- R9: Writes to register 7 at addresses below PATTERN_BYTES (default 0x2000) change nothing while pat_writable is low.
- R10: Addresses 0x3F00–0x3FFF use a 32-entry palette indexed by address bits [4:0], repeating every 0x20. Indices 0x10, 0x14, 0x18 and 0x1C alias 0x00, 0x04, 0x08 and 0x0C.
- R11: A write to register 3 loads the sprite-attribute pointer. Reads and writes of register 4 use the entry at the pointer and then increment it, wrapping at OAM_DEPTH.
- R12: Register reads are registered: cpu_rdata holds the result from the edge that samples the read until the next read. Reads of registers 0, 1, 3, 5 and 6 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Bus access strobe, one access per cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register select |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| vblank_set | input | 1 | One-cycle pulse that sets the vblank flag |
| pat_writable | input | 1 | Allows writes to the pattern region |
| vmem_addr | output | 14 | Video memory address (current address) |
| vmem_we | output | 1 | Video memory write strobe |
| vmem_wdata | output | 8 | Video memory write data |
| vmem_rdata | input | 8 | Video memory read data, combinational from vmem_addr |
| ctrl_o | output | 8 | Control byte |
| mask_o | output | 8 | Mask byte |
| vblank_o | output | 1 | Vblank flag |
| tmp_addr_o | output | 15 | Temporary address |
| vaddr_o | output | 15 | Current video address |
| fine_x_o | output | 3 | Fine horizontal scroll |
| write_toggle_o | output | 1 | Shared write-order toggle |

## Verification
The properties assume one bus access per cycle. They also assume that vmem_rdata is a function of vmem_addr within the same cycle, since the buffer refill samples it in the read's own cycle. The bench drives each access for exactly one cycle, with idle cycles in between. It drives vblank_set either alone or with a status read, and never with a read of any other register. Its memory model reads combinationally and repeats every 2 KiB, and the reference model applies that same repetition.

// File: rtl/vid_regif_pkg.sv
package vid_regif_pkg;

    localparam int TADDR_W     = 15;
    localparam int VMEM_AW     = 14;
    localparam int PAL_ENTRIES = 32;
    localparam int PAL_AW      = $clog2(PAL_ENTRIES);

    typedef enum logic [2:0] {
        SEL_CTRL     = 3'd0,
        SEL_MASK     = 3'd1,
        SEL_STATUS   = 3'd2,
        SEL_SPR_ADDR = 3'd3,
        SEL_SPR_DATA = 3'd4,
        SEL_SCROLL   = 3'd5,
        SEL_VADDR    = 3'd6,
        SEL_VDATA    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic ctrl_wr;
        logic mask_wr;
        logic status_rd;
        logic spr_addr_wr;
        logic spr_data_wr;
        logic spr_data_rd;
        logic scroll_wr;
        logic vaddr_wr;
        logic vdata_wr;
        logic vdata_rd;
        logic zero_rd;
    } bus_strobes_t;

    function automatic bus_strobes_t decode_bus(input logic sel, input logic we,
                                                input logic [2:0] a);
        bus_strobes_t s;
        s = '0;
        if (sel) begin
            case (reg_sel_e'(a))
                SEL_CTRL:     begin s.ctrl_wr = we;     s.zero_rd = !we; end
                SEL_MASK:     begin s.mask_wr = we;     s.zero_rd = !we; end
                SEL_STATUS:   s.status_rd = !we;
                SEL_SPR_ADDR: begin s.spr_addr_wr = we; s.zero_rd = !we; end
                SEL_SPR_DATA: begin s.spr_data_wr = we; s.spr_data_rd = !we; end
                SEL_SCROLL:   begin s.scroll_wr = we;   s.zero_rd = !we; end
                SEL_VADDR:    begin s.vaddr_wr = we;    s.zero_rd = !we; end
                SEL_VDATA:    begin s.vdata_wr = we;    s.vdata_rd = !we; end
                default:      ;
            endcase
        end
        return s;
    endfunction

    // Entries whose two low bits are zero fold onto the lower half.
    function automatic logic [PAL_AW-1:0] pal_slot(input logic [PAL_AW-1:0] idx);
        return (idx[1:0] == 2'b00) ? {1'b0, idx[PAL_AW-2:0]} : idx;
    endfunction

    function automatic logic [TADDR_W-1:0] vaddr_step(input logic [TADDR_W-1:0] v,
                                                      input logic wide);
        return v + (wide ? TADDR_W'(32) : TADDR_W'(1));
    endfunction

endpackage

// File: rtl/vid_addr_regs.sv
module vid_addr_regs
    import vid_regif_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ctrl_wr,
    input  logic               scroll_wr,
    input  logic               vaddr_wr,
    input  logic               status_rd,
    input  logic               step,
    input  logic               step_wide,
    input  logic [7:0]         wdata,
    output logic [TADDR_W-1:0] t_o,
    output logic [TADDR_W-1:0] v_o,
    output logic [2:0]         fine_x_o,
    output logic               toggle_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            t_o      <= '0;
            v_o      <= '0;
            fine_x_o <= '0;
            toggle_o <= 1'b0;
        end else begin
            if (status_rd) begin
                toggle_o <= 1'b0;
            end else if (scroll_wr || vaddr_wr) begin
                toggle_o <= ~toggle_o;
            end

            if (ctrl_wr) begin
                t_o[11:10] <= wdata[1:0];
            end

            if (scroll_wr) begin
                if (!toggle_o) begin
                    t_o[4:0] <= wdata[7:3];
                    fine_x_o <= wdata[2:0];
                end else begin
                    t_o[9:5]   <= wdata[7:3];
                    t_o[14:12] <= wdata[2:0];
                end
            end

            if (vaddr_wr) begin
                if (!toggle_o) begin
                    t_o[13:8] <= wdata[5:0];
                    t_o[14]   <= 1'b0;
                end else begin
                    t_o[7:0] <= wdata;
                    v_o      <= {1'b0, t_o[13:8], wdata};
                end
            end else if (step) begin
                v_o <= vaddr_step(v_o, step_wide);
            end
        end
    end

endmodule

// File: rtl/vid_palette_ram.sv
module vid_palette_ram
    import vid_regif_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [PAL_AW-1:0] idx,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic [7:0]        entries [PAL_ENTRIES];
    logic [PAL_AW-1:0] slot;

    assign slot  = pal_slot(idx);
    assign rdata = entries[slot];

    always_ff @(posedge clk) begin
        if (we) begin
            entries[slot] <= wdata;
        end
    end

endmodule

// File: rtl/vid_spr_ram.sv
module vid_spr_ram #(
    parameter int DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ptr_wr,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);

    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] ptr;

    assign rdata = mem[ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ptr_wr) begin
            ptr <= wdata[AW-1:0];
        end else if (data_wr || data_rd) begin
            ptr <= ptr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (data_wr) begin
            mem[ptr] <= wdata;
        end
    end

endmodule

// File: rtl/vid_regif.sv
module vid_regif
    import vid_regif_pkg::*;
#(
    parameter int PATTERN_BYTES = 'h2000,
    parameter int OAM_DEPTH     = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_sel,
    input  logic               cpu_we,
    input  logic [2:0]         cpu_addr,
    input  logic [7:0]         cpu_wdata,
    output logic [7:0]         cpu_rdata,
    input  logic               vblank_set,
    input  logic               pat_writable,
    output logic [VMEM_AW-1:0] vmem_addr,
    output logic               vmem_we,
    output logic [7:0]         vmem_wdata,
    input  logic [7:0]         vmem_rdata,
    output logic [7:0]         ctrl_o,
    output logic [7:0]         mask_o,
    output logic               vblank_o,
    output logic [TADDR_W-1:0] tmp_addr_o,
    output logic [TADDR_W-1:0] vaddr_o,
    output logic [2:0]         fine_x_o,
    output logic               write_toggle_o
);

    localparam logic [VMEM_AW-1:0] PAT_LIMIT = VMEM_AW'(PATTERN_BYTES);
    localparam logic [5:0]         PAL_PAGE  = 6'h3F;

    bus_strobes_t       stb;
    logic [VMEM_AW-1:0] cur_addr;
    logic               in_palette;
    logic               write_locked;
    logic [7:0]         pal_rdata;
    logic [7:0]         spr_rdata;
    logic [7:0]         read_buf;

    assign stb          = decode_bus(cpu_sel, cpu_we, cpu_addr);
    assign cur_addr     = vaddr_o[VMEM_AW-1:0];
    assign in_palette   = (cur_addr[13:8] == PAL_PAGE);
    assign write_locked = (cur_addr < PAT_LIMIT) && !pat_writable;

    assign vmem_addr  = cur_addr;
    assign vmem_wdata = cpu_wdata;
    assign vmem_we    = stb.vdata_wr && !in_palette && !write_locked;

    vid_addr_regs u_addr (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (stb.ctrl_wr),
        .scroll_wr (stb.scroll_wr),
        .vaddr_wr  (stb.vaddr_wr),
        .status_rd (stb.status_rd),
        .step      (stb.vdata_wr || stb.vdata_rd),
        .step_wide (ctrl_o[2]),
        .wdata     (cpu_wdata),
        .t_o       (tmp_addr_o),
        .v_o       (vaddr_o),
        .fine_x_o  (fine_x_o),
        .toggle_o  (write_toggle_o)
    );

    vid_palette_ram u_pal (
        .clk   (clk),
        .we    (stb.vdata_wr && in_palette),
        .idx   (cur_addr[PAL_AW-1:0]),
        .wdata (cpu_wdata),
        .rdata (pal_rdata)
    );

    vid_spr_ram #(.DEPTH(OAM_DEPTH)) u_spr (
        .clk     (clk),
        .rst     (rst),
        .ptr_wr  (stb.spr_addr_wr),
        .data_wr (stb.spr_data_wr),
        .data_rd (stb.spr_data_rd),
        .wdata   (cpu_wdata),
        .rdata   (spr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o   <= '0;
            mask_o   <= '0;
            vblank_o <= 1'b0;
            read_buf <= '0;
        end else begin
            if (stb.ctrl_wr) ctrl_o <= cpu_wdata;
            if (stb.mask_wr) mask_o <= cpu_wdata;
            if (stb.status_rd) begin
                vblank_o <= 1'b0;
            end else if (vblank_set) begin
                vblank_o <= 1'b1;
            end
            if (stb.vdata_rd) begin
                read_buf <= in_palette ? pal_rdata : vmem_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rdata <= '0;
        end else if (stb.status_rd) begin
            cpu_rdata <= {vblank_o, 7'b0};
        end else if (stb.spr_data_rd) begin
            cpu_rdata <= spr_rdata;
        end else if (stb.vdata_rd) begin
            cpu_rdata <= read_buf;
        end else if (stb.zero_rd) begin
            cpu_rdata <= '0;
        end
    end

endmodule

// File: rtl/vid_regif_checker.sv
module vid_regif_checker
    import vid_regif_pkg::*;
#(
    parameter int PATTERN_BYTES = 'h2000
) (
    input logic               clk,
    input logic               rst,
    input logic               cpu_sel,
    input logic               cpu_we,
    input logic [2:0]         cpu_addr,
    input logic [7:0]         cpu_wdata,
    input logic               pat_writable,
    input logic [VMEM_AW-1:0] vmem_addr,
    input logic               vmem_we,
    input logic [7:0]         ctrl_o,
    input logic               vblank_o,
    input logic [TADDR_W-1:0] tmp_addr_o,
    input logic [TADDR_W-1:0] vaddr_o,
    input logic [2:0]         fine_x_o,
    input logic               write_toggle_o
);

    logic status_rd, two_step_wr, data_acc;
    assign status_rd   = cpu_sel && !cpu_we && (cpu_addr == 3'd2);
    assign two_step_wr = cpu_sel && cpu_we && (cpu_addr == 3'd5 || cpu_addr == 3'd6);
    assign data_acc    = cpu_sel && (cpu_addr == 3'd7);

    // R2: status read acknowledges vblank and resets the toggle, even against a set pulse
    assert_status_ack_R2: assert property (@(posedge clk) disable iff (rst)
        status_rd |=> (!vblank_o && !write_toggle_o));

    // R6: each two-step write inverts the toggle
    assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (rst)
        two_step_wr |=> (write_toggle_o != $past(write_toggle_o)));

    // R3: nametable select lands in t[11:10]
    assert_ctrl_select_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_sel && cpu_we && cpu_addr == 3'd0) |=> (tmp_addr_o[11:10] == $past(cpu_wdata[1:0])));

    // R4: first scroll write sets fine X
    assert_fine_x_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_sel && cpu_we && cpu_addr == 3'd5 && !write_toggle_o) |=> (fine_x_o == $past(cpu_wdata[2:0])));

    // R7: data access steps the address by the control-selected amount
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
        data_acc |=> (vaddr_o == TADDR_W'($past(vaddr_o) + ($past(ctrl_o[2]) ? 32 : 1))));

    // R9: no memory write into the locked pattern region
    assert_pattern_lock_R9: assert property (@(posedge clk) disable iff (rst)
        vmem_we |-> (pat_writable || (int'(vmem_addr) >= PATTERN_BYTES)));

endmodule

bind vid_regif vid_regif_checker #(.PATTERN_BYTES(PATTERN_BYTES)) u_vid_regif_checker (
    .clk            (clk),
    .rst            (rst),
    .cpu_sel        (cpu_sel),
    .cpu_we         (cpu_we),
    .cpu_addr       (cpu_addr),
    .cpu_wdata      (cpu_wdata),
    .pat_writable   (pat_writable),
    .vmem_addr      (vmem_addr),
    .vmem_we        (vmem_we),
    .ctrl_o         (ctrl_o),
    .vblank_o       (vblank_o),
    .tmp_addr_o     (tmp_addr_o),
    .vaddr_o        (vaddr_o),
    .fine_x_o       (fine_x_o),
    .write_toggle_o (write_toggle_o)
);

// File: tb/vid_regif_bench.sv
`timescale 1ns/1ps
module vid_regif_bench;

    localparam int PAT_BYTES = 'h2000;
    localparam int MEM_W     = 2048;   // bench memory repeats every 2 KiB

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        vblank_set = 1'b0, pat_writable = 1'b0;
    logic [13:0] vmem_addr;
    logic        vmem_we;
    logic [7:0]  vmem_wdata, vmem_rdata;
    logic [7:0]  ctrl_o, mask_o;
    logic        vblank_o;
    logic [14:0] tmp_addr_o, vaddr_o;
    logic [2:0]  fine_x_o;
    logic        write_toggle_o;

    always #2.5 clk = ~clk;

    vid_regif u_vid_regif (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .vblank_set(vblank_set),
        .pat_writable(pat_writable), .vmem_addr(vmem_addr), .vmem_we(vmem_we),
        .vmem_wdata(vmem_wdata), .vmem_rdata(vmem_rdata), .ctrl_o(ctrl_o), .mask_o(mask_o),
        .vblank_o(vblank_o), .tmp_addr_o(tmp_addr_o), .vaddr_o(vaddr_o),
        .fine_x_o(fine_x_o), .write_toggle_o(write_toggle_o)
    );

    function automatic logic [7:0] mem_init(input int i);
        return 8'(i * 13 + 7);
    endfunction

    logic [7:0] ext_mem [MEM_W];
    assign vmem_rdata = ext_mem[vmem_addr[10:0]];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_W; i++) ext_mem[i] <= mem_init(i);
        end else if (vmem_we) begin
            ext_mem[vmem_addr[10:0]] <= vmem_wdata;
        end
    end

    // Reference model state
    logic [14:0] m_t, m_v;
    logic [2:0]  m_x;
    logic        m_tog, m_vb;
    logic [7:0]  m_ctrl, m_mask, m_oaddr, m_rbuf;
    logic [7:0]  m_pal [32];
    logic [7:0]  m_oam [256];
    logic [7:0]  m_mem [MEM_W];

    int n_checks = 0;
    int n_fails  = 0;

    function automatic logic [4:0] pslot(input logic [4:0] a);
        return (a[1:0] == 2'b00) ? (a & 5'h0F) : a;
    endfunction

    function automatic void m_step();
        m_v = m_v + (m_ctrl[2] ? 15'd32 : 15'd1);
    endfunction

    function automatic void model_write(input logic [2:0] a, input logic [7:0] d);
        logic [13:0] a14;
        case (a)
            3'd0: begin m_ctrl = d; m_t[11:10] = d[1:0]; end
            3'd1: m_mask = d;
            3'd3: m_oaddr = d;
            3'd4: begin m_oam[m_oaddr] = d; m_oaddr = m_oaddr + 8'd1; end
            3'd5: begin
                if (!m_tog) begin m_t[4:0] = d[7:3]; m_x = d[2:0]; end
                else begin m_t[9:5] = d[7:3]; m_t[14:12] = d[2:0]; end
                m_tog = ~m_tog;
            end
            3'd6: begin
                if (!m_tog) begin m_t[13:8] = d[5:0]; m_t[14] = 1'b0; end
                else begin m_t[7:0] = d; m_v = {1'b0, m_t[13:0]}; end
                m_tog = ~m_tog;
            end
            3'd7: begin
                a14 = m_v[13:0];
                if (a14[13:8] == 6'h3F) m_pal[pslot(a14[4:0])] = d;
                else if (int'(a14) >= PAT_BYTES || pat_writable) m_mem[a14[10:0]] = d;
                m_step();
            end
            default: ;
        endcase
    endfunction

    function automatic logic [7:0] model_read(input logic [2:0] a);
        logic [7:0]  r;
        logic [13:0] a14;
        r = 8'h00;
        case (a)
            3'd2: begin r = {m_vb, 7'b0}; m_vb = 1'b0; m_tog = 1'b0; end
            3'd4: begin r = m_oam[m_oaddr]; m_oaddr = m_oaddr + 8'd1; end
            3'd7: begin
                r = m_rbuf;
                a14 = m_v[13:0];
                m_rbuf = (a14[13:8] == 6'h3F) ? m_pal[pslot(a14[4:0])] : m_mem[a14[10:0]];
                m_step();
            end
            default: ;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        check({tag, " t"},      int'(tmp_addr_o),     int'(m_t));
        check({tag, " v"},      int'(vaddr_o),        int'(m_v));
        check({tag, " fineX"},  int'(fine_x_o),       int'(m_x));
        check({tag, " toggle"}, int'(write_toggle_o), int'(m_tog));
        check({tag, " vblank"}, int'(vblank_o),       int'(m_vb));
        check({tag, " ctrl"},   int'(ctrl_o),         int'(m_ctrl));
        check({tag, " mask"},   int'(mask_o),         int'(m_mask));
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_rd(input logic [2:0] a, input logic with_set, input string tag);
        logic [7:0] exp;
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a; vblank_set = with_set;
        @(negedge clk);
        cpu_sel = 1'b0; vblank_set = 1'b0;
        exp = model_read(a);
        check({tag, " rdata"}, int'(cpu_rdata), int'(exp));
    endtask

    task automatic vb_pulse();
        @(negedge clk);
        vblank_set = 1'b1;
        @(negedge clk);
        vblank_set = 1'b0;
        m_vb = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_2024));
        m_t = '0; m_v = '0; m_x = '0; m_tog = 1'b0; m_vb = 1'b0;
        m_ctrl = '0; m_mask = '0; m_oaddr = '0; m_rbuf = '0;
        for (int i = 0; i < MEM_W; i++) m_mem[i] = mem_init(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values
        check_state("R1 reset");
        check("R1 rdata", int'(cpu_rdata), 0);

        // R11: fill sprite memory, then read across the pointer wrap
        bus_wr(3'd3, 8'h00);
        for (int i = 0; i < 256; i++) bus_wr(3'd4, 8'(i * 3 + 1));
        bus_wr(3'd3, 8'hFE);
        bus_rd(3'd4, 1'b0, "R11 spr FE");
        bus_rd(3'd4, 1'b0, "R11 spr FF");
        bus_rd(3'd4, 1'b0, "R11 spr wrap 00");

        // R10 / R5: fill palette, probe alias and 0x20 repetition
        bus_wr(3'd6, 8'h3F); bus_wr(3'd6, 8'h00);
        check_state("R5 addr copy");
        for (int i = 0; i < 32; i++) bus_wr(3'd7, 8'(i ^ 8'h55));
        bus_wr(3'd6, 8'h3F); bus_wr(3'd6, 8'h10);
        bus_rd(3'd7, 1'b0, "R7 old buffer");
        bus_rd(3'd7, 1'b0, "R10 alias 10->00");
        bus_wr(3'd6, 8'h3F); bus_wr(3'd6, 8'h25);
        bus_rd(3'd7, 1'b0, "R10 repeat prime");
        bus_rd(3'd7, 1'b0, "R10 repeat 25->05");

        // R4 / R6 / R3: scroll, address, control packing
        bus_wr(3'd5, 8'hAD); check_state("R4 scroll first");
        bus_wr(3'd5, 8'h5E); check_state("R4 scroll second R6");
        bus_wr(3'd0, 8'h07); check_state("R3 ctrl");
        bus_wr(3'd6, 8'h21); check_state("R5 addr first R6");
        bus_wr(3'd6, 8'h08); check_state("R5 addr second");
        bus_wr(3'd7, 8'h99); check_state("R3 step 32 R8");
        bus_wr(3'd0, 8'h00);
        bus_wr(3'd7, 8'h9A); check_state("R3 step 1 R8");

        // R2: status read, including a simultaneous set pulse
        bus_wr(3'd5, 8'h01);
        vb_pulse(); check_state("R2 set");
        bus_rd(3'd2, 1'b0, "R2 status");
        check_state("R2 cleared");
        vb_pulse();
        bus_rd(3'd2, 1'b1, "R2 set+read");
        check_state("R2 read wins");
        bus_rd(3'd2, 1'b1, "R2 idle set+read");
        check_state("R2 read wins idle");

        // R9: pattern lock then unlock
        pat_writable = 1'b0;
        bus_wr(3'd6, 8'h01); bus_wr(3'd6, 8'h00);
        bus_wr(3'd7, 8'hAB);
        bus_wr(3'd6, 8'h01); bus_wr(3'd6, 8'h00);
        bus_rd(3'd7, 1'b0, "R9 prime");
        bus_rd(3'd7, 1'b0, "R9 locked unchanged");
        pat_writable = 1'b1;
        bus_wr(3'd6, 8'h01); bus_wr(3'd6, 8'h00);
        bus_wr(3'd7, 8'hAB);
        bus_wr(3'd6, 8'h01); bus_wr(3'd6, 8'h00);
        bus_rd(3'd7, 1'b0, "R9 prime2");
        bus_rd(3'd7, 1'b0, "R9 unlocked write R8");

        // R12: write-only registers read as zero
        bus_rd(3'd0, 1'b0, "R12 ctrl reads 0");
        bus_rd(3'd6, 1'b0, "R12 addr reads 0");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [7:0] d;
            op = int'($urandom_range(0, 15));
            d  = 8'($urandom);
            if ($urandom_range(0, 63) == 0) pat_writable = ~pat_writable;
            case (op)
                0, 1:   begin bus_wr(3'd0, d); check_state("R3 rnd"); end
                2:      begin bus_wr(3'd1, d); check_state("R12 rnd mask"); end
                3:      begin bus_rd(3'd2, 1'($urandom_range(0, 1)), "R2 rnd"); check_state("R2 rnd"); end
                4, 5:   begin bus_wr(3'd5, d); check_state("R4 rnd R6"); end
                6, 7:   begin bus_wr(3'd6, d); check_state("R5 rnd R6"); end
                8, 9, 10: begin bus_wr(3'd7, d); check_state("R8 rnd"); end
                11, 12: begin bus_rd(3'd7, 1'b0, "R7 rnd"); check_state("R7 rnd"); end
                13:     begin
                    if (d[0]) bus_wr(3'd4, d); else bus_rd(3'd4, 1'b0, "R11 rnd");
                end
                14:     begin vb_pulse(); check_state("R2 rnd pulse"); end
                default: begin
                    logic [2:0] a;
                    a = 3'($urandom);
                    if (a == 3'd2 || a == 3'd4 || a == 3'd7) a = 3'd1;
                    bus_rd(a, 1'b0, "R12 rnd");
                end
            endcase
        end

        // R10 / R8 final palette sweep through buffered reads
        bus_wr(3'd0, 8'h00);
        bus_wr(3'd6, 8'h3F); bus_wr(3'd6, 8'h00);
        for (int i = 0; i < 33; i++) bus_rd(3'd7, 1'b0, "R10 sweep");

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule